// File: doc/BRIEF.md
# Inverse Park Transform with Sector-Clamped Three-Phase Duty Generation

This block turns a voltage command given in the rotor frame into three per-phase duty values for a three-phase bridge. A single 32-bit word carries the command: the direct part and the quadrature part, both signed 16-bit. The block also takes the signed 16-bit sine and cosine of the rotor angle. It rotates the command into the stationary alpha/beta frame and then picks one of three sector groups from the signs and magnitudes of alpha and a scaled beta. Within that group, one phase is held at zero and the other two are built from fixed-point sums. No minimum or maximum search is needed.

A one-cycle start strobe loads a new set of operands. The result appears as three 16-bit channel words with a one-cycle valid strobe, a fixed four clock edges later. The pipeline takes a new start on every cycle, so a stream of commands gives a stream of results with no gaps. Generating the PWM counter and inserting dead time are left to the logic downstream.

Top module: `ipark_svpwm`

## Requirements
- R1: The command word splits into a direct part d (bits 31:16) and a quadrature part q (bits 15:0), and each is read as signed two's complement. The sine s and the cosine c are signed 16-bit.
- R2: The block forms alpha = d*c - q*s and beta = d*s + q*c, each kept as a 32-bit signed value that wraps on overflow.
- R3: The scaled beta is sb = 37837 * (beta >>> 16), truncated to 32-bit signed. The constant 37837 is 65536/sqrt(3).
- R4: Sector group P applies when beta >= 0 and group N does not apply. Phase 1 = (alpha + sb) >>> 16, phase 2 = sb >>> 15, and phase 3 = 0.
- R5: Group N applies when alpha < 0 and ma >= mb. Here ma = -alpha-1 and mb = |sb|, both compared without wrap. Phase 1 = 0, phase 2 = (sb - alpha) >>> 16, and phase 3 = (-sb - alpha) >>> 16.
- R6: Group M applies when beta < 0 and group N does not apply. Phase 1 = (alpha - sb) >>> 16, phase 2 = 0, and phase 3 = (-sb) >>> 15.
- R7: Each channel word holds the low 14 bits of its phase value in bits 13:0. Bit 14 is always 1 as an enable flag, and bit 15 is 0.
- R8: Channel 0 carries phase 2, channel 1 carries phase 3, and channel 2 carries phase 1.
- R9: `res_valid` goes high for exactly one cycle for each start. It is high in the cycle after the fourth rising edge that follows the start being sampled. Starts on consecutive cycles each give their own result, in order.
- R10: While reset is high, and in the cycle right after it, `res_valid` is 0 and all three channel words are 0.
- R11: In a cycle where `res_valid` is low, the three channel words hold the values of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle strobe that loads the operands below |
| cmd_dq | input | 32 | Packed command: direct part in 31:16, quadrature part in 15:0 |
| rot_sin | input | 16 | Signed sine of the rotor angle |
| rot_cos | input | 16 | Signed cosine of the rotor angle |
| ch0_word | output | 16 | Enable flag and duty of phase 2 |
| ch1_word | output | 16 | Enable flag and duty of phase 3 |
| ch2_word | output | 16 | Enable flag and duty of phase 1 |
| res_valid | output | 1 | One-cycle strobe marking new channel words |

## Verification
In one cycle, the pipeline can take a new start while an earlier operand set is leaving the output register. The same thing happens whenever several commands sit in different stages at once. The bench provokes this with runs of starts on back-to-back cycles, spread across all eight angle octants, mixed with isolated starts and idle gaps. A scoreboard matches each emerging result, in order, against a model written from the requirements. It also checks that each result arrives exactly four edges after its own start, so a stage that mixes up two commands in flight shows up as a wrong value or a wrong arrival cycle.

// File: rtl/ipark_svpwm_pkg.sv
package ipark_svpwm_pkg;
  typedef enum logic [1:0] {
    GRP_P = 2'd0,
    GRP_N = 2'd1,
    GRP_M = 2'd2
  } grp_t;

  localparam int unsigned SCALE_K = 37837;
endpackage

// File: rtl/ipark_rotate.sv
module ipark_rotate #(
  parameter int TRIG_W = 16,
  parameter int CMD_W  = 32,
  localparam int ACC_W = 2 * TRIG_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_vld,
  input  logic [CMD_W-1:0]         cmd,
  input  logic signed [TRIG_W-1:0] s_in,
  input  logic signed [TRIG_W-1:0] c_in,
  output logic                     out_vld,
  output logic signed [ACC_W-1:0]  alpha,
  output logic signed [ACC_W-1:0]  beta
);
  logic signed [TRIG_W-1:0] d_op;
  logic signed [TRIG_W-1:0] q_op;
  logic signed [ACC_W-1:0]  dc, qs, ds, qc;

  always_comb begin
    d_op = $signed(cmd[CMD_W-1 -: TRIG_W]);
    q_op = $signed(cmd[TRIG_W-1:0]);
    dc   = ACC_W'(d_op * c_in);
    qs   = ACC_W'(q_op * s_in);
    ds   = ACC_W'(d_op * s_in);
    qc   = ACC_W'(q_op * c_in);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      alpha   <= '0;
      beta    <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        alpha <= dc - qs;
        beta  <= ds + qc;
      end
    end
  end
endmodule

// File: rtl/ipark_sector.sv
module ipark_sector
  import ipark_svpwm_pkg::*;
#(
  parameter int ACC_W = 32,
  localparam int HALF_W = ACC_W / 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_vld,
  input  logic signed [ACC_W-1:0] alpha,
  input  logic signed [ACC_W-1:0] beta,
  output logic                    out_vld,
  output logic signed [ACC_W-1:0] alpha_q,
  output logic signed [ACC_W-1:0] sb_q,
  output grp_t                    grp_q
);
  logic signed [HALF_W-1:0] beta_hi;
  logic signed [ACC_W-1:0]  sb_c;
  logic signed [ACC_W:0]    mag_a, mag_b, diff;
  grp_t                     grp_c;

  always_comb begin
    beta_hi = beta[ACC_W-1 -: HALF_W];
    sb_c    = ACC_W'($signed(ACC_W'(SCALE_K)) * ACC_W'(beta_hi));
    mag_a   = alpha[ACC_W-1] ? (ACC_W+1)'(~alpha) : (ACC_W+1)'(alpha);
    mag_b   = beta[ACC_W-1] ? -(ACC_W+1)'(sb_c) : (ACC_W+1)'(sb_c);
    diff    = mag_a - mag_b;
    if (alpha[ACC_W-1] && !diff[ACC_W])
      grp_c = GRP_N;
    else if (beta[ACC_W-1])
      grp_c = GRP_M;
    else
      grp_c = GRP_P;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      alpha_q <= '0;
      sb_q    <= '0;
      grp_q   <= GRP_P;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        alpha_q <= alpha;
        sb_q    <= sb_c;
        grp_q   <= grp_c;
      end
    end
  end
endmodule

// File: rtl/ipark_phase.sv
module ipark_phase
  import ipark_svpwm_pkg::*;
#(
  parameter int ACC_W  = 32,
  parameter int DUTY_W = 14,
  localparam int FRAC  = ACC_W / 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_vld,
  input  logic signed [ACC_W-1:0] alpha,
  input  logic signed [ACC_W-1:0] sb,
  input  grp_t                    grp,
  output logic                    out_vld,
  output logic [DUTY_W-1:0]       duty1,
  output logic [DUTY_W-1:0]       duty2,
  output logic [DUTY_W-1:0]       duty3
);
  logic signed [ACC_W-1:0] a_plus, a_minus, sb_m_a, nsb_m_a, nsb;
  logic [DUTY_W-1:0]       d1_c, d2_c, d3_c;

  always_comb begin
    a_plus  = alpha + sb;
    a_minus = alpha - sb;
    sb_m_a  = sb - alpha;
    nsb_m_a = -sb - alpha;
    nsb     = -sb;
    d1_c = '0;
    d2_c = '0;
    d3_c = '0;
    unique case (grp)
      GRP_N: begin
        d2_c = sb_m_a[FRAC +: DUTY_W];
        d3_c = nsb_m_a[FRAC +: DUTY_W];
      end
      GRP_M: begin
        d1_c = a_minus[FRAC +: DUTY_W];
        d3_c = nsb[FRAC-1 +: DUTY_W];
      end
      default: begin
        d1_c = a_plus[FRAC +: DUTY_W];
        d2_c = sb[FRAC-1 +: DUTY_W];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      duty1   <= '0;
      duty2   <= '0;
      duty3   <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        duty1 <= d1_c;
        duty2 <= d2_c;
        duty3 <= d3_c;
      end
    end
  end
endmodule

// File: rtl/ipark_svpwm.sv
module ipark_svpwm
  import ipark_svpwm_pkg::*;
#(
  parameter int TRIG_W = 16,
  parameter int DUTY_W = 14,
  parameter int WORD_W = 16,
  localparam int CMD_W = 2 * TRIG_W,
  localparam int ACC_W = 2 * TRIG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CMD_W-1:0]  cmd_dq,
  input  logic [TRIG_W-1:0] rot_sin,
  input  logic [TRIG_W-1:0] rot_cos,
  output logic [WORD_W-1:0] ch0_word,
  output logic [WORD_W-1:0] ch1_word,
  output logic [WORD_W-1:0] ch2_word,
  output logic              res_valid
);
  localparam int PAD_W = WORD_W - DUTY_W - 1;

  logic                    v1, v2, v3;
  logic signed [ACC_W-1:0] alpha1, beta1, alpha2, sb2;
  grp_t                    grp2;
  logic [DUTY_W-1:0]       p1, p2, p3;

  ipark_rotate #(.TRIG_W(TRIG_W), .CMD_W(CMD_W)) u_rot (
    .clk(clk), .rst(rst), .in_vld(start), .cmd(cmd_dq),
    .s_in($signed(rot_sin)), .c_in($signed(rot_cos)),
    .out_vld(v1), .alpha(alpha1), .beta(beta1)
  );

  ipark_sector #(.ACC_W(ACC_W)) u_sec (
    .clk(clk), .rst(rst), .in_vld(v1), .alpha(alpha1), .beta(beta1),
    .out_vld(v2), .alpha_q(alpha2), .sb_q(sb2), .grp_q(grp2)
  );

  ipark_phase #(.ACC_W(ACC_W), .DUTY_W(DUTY_W)) u_phs (
    .clk(clk), .rst(rst), .in_vld(v2), .alpha(alpha2), .sb(sb2), .grp(grp2),
    .out_vld(v3), .duty1(p1), .duty2(p2), .duty3(p3)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      ch0_word  <= '0;
      ch1_word  <= '0;
      ch2_word  <= '0;
    end else begin
      res_valid <= v3;
      if (v3) begin
        ch0_word <= {{PAD_W{1'b0}}, 1'b1, p2};
        ch1_word <= {{PAD_W{1'b0}}, 1'b1, p3};
        ch2_word <= {{PAD_W{1'b0}}, 1'b1, p1};
      end
    end
  end
endmodule

// File: rtl/ipark_svpwm_chk.sv
module ipark_svpwm_chk #(
  parameter int WORD_W = 16,
  parameter int DUTY_W = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [WORD_W-1:0] ch0_word,
  input logic [WORD_W-1:0] ch1_word,
  input logic [WORD_W-1:0] ch2_word,
  input logic              res_valid
);
  logic [2:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  // R9: one strobe per start, exactly four edges later
  p_latency_r9: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd4) |-> (res_valid == $past(start, 4)));

  // R7: enable flag set and top bit clear on every delivered word
  p_flag_r7: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (ch0_word[DUTY_W] && ch1_word[DUTY_W] && ch2_word[DUTY_W]
                   && ch0_word[WORD_W-1] == 1'b0 && ch1_word[WORD_W-1] == 1'b0
                   && ch2_word[WORD_W-1] == 1'b0));

  // R4 R5 R6: at least one phase is clamped to zero in every result
  p_clamp_r5: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (ch0_word[DUTY_W-1:0] == '0 || ch1_word[DUTY_W-1:0] == '0
                   || ch2_word[DUTY_W-1:0] == '0));

  // R11: words hold when no strobe
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd1 && !res_valid) |->
      ($stable(ch0_word) && $stable(ch1_word) && $stable(ch2_word)));

  // R10: cleared right after reset
  p_reset_r10: assert property (@(posedge clk)
    (since_rst == 3'd1) |-> (!res_valid && ch0_word == '0 && ch1_word == '0
                             && ch2_word == '0));
endmodule

bind ipark_svpwm ipark_svpwm_chk #(.WORD_W(WORD_W), .DUTY_W(DUTY_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .ch0_word(ch0_word),
  .ch1_word(ch1_word), .ch2_word(ch2_word), .res_valid(res_valid)
);

// File: tb/ipark_svpwm_tb.sv
module ipark_svpwm_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] cmd_dq = '0;
  logic [15:0] rot_sin = '0;
  logic [15:0] rot_cos = '0;
  logic [15:0] ch0_word, ch1_word, ch2_word;
  logic        res_valid;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int seen_p = 0, seen_n = 0, seen_m = 0;
  bit done = 1'b0;

  typedef struct {
    logic [15:0] w0, w1, w2;
    int          due;
  } exp_t;
  exp_t sb_q[$];

  ipark_svpwm u_dut (
    .clk(clk), .rst(rst), .start(start), .cmd_dq(cmd_dq),
    .rot_sin(rot_sin), .rot_cos(rot_cos), .ch0_word(ch0_word),
    .ch1_word(ch1_word), .ch2_word(ch2_word), .res_valid(res_valid)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference model built from R1..R8
  function automatic exp_t model(input int d, input int q, input int s, input int c);
    exp_t e;
    int alpha, beta, sbv, ph1, ph2, ph3;
    longint ma, mb;
    alpha = d * c - q * s;                      // R2
    beta  = d * s + q * c;
    sbv   = 37837 * (beta >>> 16);              // R3
    ma = (alpha < 0) ? -longint'(alpha) - 1 : longint'(alpha);
    mb = (beta < 0) ? -longint'(sbv) : longint'(sbv);
    if (alpha < 0 && ma >= mb) begin            // R5
      ph1 = 0; ph2 = (sbv - alpha) >>> 16; ph3 = (-sbv - alpha) >>> 16;
      seen_n++;
    end else if (beta < 0) begin                // R6
      ph1 = (alpha - sbv) >>> 16; ph2 = 0; ph3 = (-sbv) >>> 15;
      seen_m++;
    end else begin                              // R4
      ph1 = (alpha + sbv) >>> 16; ph2 = sbv >>> 15; ph3 = 0;
      seen_p++;
    end
    e.w0 = 16'h4000 | 16'(ph2 & 32'h3fff);      // R7, R8
    e.w1 = 16'h4000 | 16'(ph3 & 32'h3fff);
    e.w2 = 16'h4000 | 16'(ph1 & 32'h3fff);
    e.due = 0;
    return e;
  endfunction

  // Driver: sets operands at a falling edge and keeps start high for one cycle
  task automatic send(input int d, input int q, input int s, input int c);
    exp_t e;
    e = model(d, q, s, c);
    cmd_dq  = {16'(d), 16'(q)};                 // R1 packing
    rot_sin = 16'(s);
    rot_cos = 16'(c);
    start   = 1'b1;
    e.due   = cyc + 4;
    sb_q.push_back(e);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R9", "unexpected strobe", 64'(cyc), 64'(0));
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(cyc == e.due, "R9", "arrival cycle", 64'(cyc), 64'(e.due));
        check(ch0_word == e.w0, "R8", "ch0 (phase 2)", 64'(ch0_word), 64'(e.w0));
        check(ch1_word == e.w1, "R8", "ch1 (phase 3)", 64'(ch1_word), 64'(e.w1));
        check(ch2_word == e.w2, "R8", "ch2 (phase 1)", 64'(ch2_word), 64'(e.w2));
      end
    end
  end

  int ang_c[8] = '{32767, 23170, 0, -23170, -32767, -23170, 0, 23170};
  int ang_s[8] = '{0, 23170, 32767, 23170, 0, -23170, -32767, -23170};
  int dv[3] = '{6000, 12000, -5000};
  int qv[3] = '{0, 3000, -7000};

  initial begin
    logic [15:0] h0, h1, h2;
    idle(3);
    check(res_valid == 1'b0, "R10", "valid in reset", 64'(res_valid), 64'(0));
    check(ch0_word == 0 && ch1_word == 0 && ch2_word == 0, "R10", "words in reset",
          64'({ch0_word, ch1_word, ch2_word}), 64'(0));
    rst = 1'b0;
    @(negedge clk);
    check(res_valid == 1'b0, "R10", "valid after reset", 64'(res_valid), 64'(0));

    // Known value: d=8000, angle 0 -> group P, phase1 = 3999, others 0 (R4)
    send(8000, 0, 0, 32767);
    idle(6);
    check(ch2_word == 16'h4f9f, "R4", "phase1 at angle 0", 64'(ch2_word), 64'h4f9f);
    // R11: words hold during idle
    h0 = ch0_word; h1 = ch1_word; h2 = ch2_word;
    idle(5);
    check(ch0_word == h0 && ch1_word == h1 && ch2_word == h2, "R11", "hold while idle",
          64'({ch0_word, ch1_word, ch2_word}), 64'({h0, h1, h2}));

    // Isolated starts over all octants
    for (int a = 0; a < 8; a++) begin
      send(dv[0], qv[1], ang_s[a], ang_c[a]);
      idle(5);
    end
    // Back-to-back runs: new start accepted while older results emerge (R9)
    for (int a = 0; a < 8; a++)
      for (int i = 0; i < 3; i++)
        for (int j = 0; j < 3; j++)
          send(dv[i], qv[j], ang_s[a], ang_c[a]);
    idle(2);
    // Large command to exercise 14-bit truncation (R7)
    send(32767, 32767, 32767, 32767);
    send(-32768, 32767, -32768, 32767);
    send(-32768, -32768, 12345, -23456);
    idle(10);

    check(seen_p > 0, "R4", "group P exercised", 64'(seen_p), 64'(1));
    check(seen_n > 0, "R5", "group N exercised", 64'(seen_n), 64'(1));
    check(seen_m > 0, "R6", "group M exercised", 64'(seen_m), 64'(1));
    check(sb_q.size() == 0, "R9", "results outstanding", 64'(sb_q.size()), 64'(0));
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        check(1'b0, "R9", "watchdog expired", 64'(cyc), 64'(0));
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule